// File: doc/BRIEF.md
# SMBus Block-Write Configuration Slave

This block is a receive-only serial slave on a two-wire bus. It takes SMBus-style block writes and stores the data bytes into a small bank of byte-wide control registers. A typical use is a bank of output-enable bits for a clock fan-out buffer. The host sends a start condition and the fixed 7-bit device address with the write direction bit. It follows with a command byte, then a byte count N, then up to N data bytes. The slave acknowledges each accepted byte by pulling the data line low.

Data bytes always land in ascending register order, beginning at register 0. No index or offset is carried on the bus. The host may end the transfer with a stop after any whole byte, and registers already written keep their new values. The clock and data inputs are oversampled on the system clock through two-stage synchronisers. The acknowledge is driven as an open-drain pull-down enable. The register bank comes out of reset as all ones, so every controlled output is enabled.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset every register bit reads 1 and the pull-down output is 0.
- R2: The address byte is acknowledged only when its upper seven bits equal 7'b1101001 (0x69) and its lowest bit, the direction bit, is 0. Any other address byte gets no acknowledge, and the rest of the transfer changes no register.
- R3: After an acknowledged address, the next byte (the command code) is acknowledged whatever its value.
- R4: The third byte is the byte count N. It is acknowledged when 1 <= N <= 32. A count of 0 or above 32 gets no acknowledge, and no following data byte is stored.
- R5: Data byte k (k = 0, 1, ...) is acknowledged and written to register k, bits [8k+7:8k] of the register bus.
- R6: A data byte with index k >= N, or k >= the number of registers (4), gets no acknowledge and is not stored. No byte after it is stored either.
- R7: A stop after any complete byte leaves the registers already written holding their new values. A byte cut short by a stop or start before its eighth bit is not stored.
- R8: A start or repeated start in any state restarts address reception, so a new transfer can begin without an intervening stop.
- R9: The pull-down output changes only while the synchronised clock line is low. It is never asserted while the slave is idle or ignoring the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the wire, asynchronous |
| sda_pd_o | output | 1 | When 1, the data line is pulled low (acknowledge) |
| regs_o | output | NREGS*8 | Register bank, register k in bits [8k+7:8k] |

## Verification
The assertions check on every cycle the following properties. A register may change only in the cycle the acknowledge starts. The pull-down moves only while the synchronised clock is low and is off in the idle and ignore states. The data index never passes the bank size, and the bit counter stays in range. Only the bench's transfers can show the rest: address and direction matching, the byte-count window, the ascending placement of data, and the discarding of extra or truncated bytes. The same goes for restart through a repeated start. Each of these is checked against acknowledges and register values predicted by a bench-side model.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NREGS     = 4,
  parameter int         MAX_COUNT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pd_o,
  output logic [NREGS*8-1:0] regs_o
);
  localparam int         RW   = NREGS * 8;
  localparam logic [7:0] MAXC = 8'(MAX_COUNT);
  localparam logic [7:0] NR8  = 8'(NREGS);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_DATA, S_SKIP} st_t;

  logic [2:0] scl_p, sda_p;
  st_t        st, nxt_q, nxt_w;
  logic [3:0] bit_q;
  logic       in_ack, byte_ok;
  logic [7:0] sr, cnt_q, dcnt_q;
  logic [RW-1:0] regs_q;

  wire scl_s = scl_p[1];
  wire scl_o = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_o = sda_p[2];
  wire start_w = scl_s & scl_o & sda_o & ~sda_s;
  wire stop_w  = scl_s & scl_o & ~sda_o & sda_s;
  wire rise_w  = scl_s & ~scl_o;
  wire fall_w  = ~scl_s & scl_o;
  wire active  = (st != S_IDLE) && (st != S_SKIP);

  assign regs_o = regs_q;

  always_comb begin
    byte_ok = 1'b0;
    nxt_w   = S_SKIP;
    case (st)
      S_ADDR: begin byte_ok = (sr == {DEV_ADDR, 1'b0}); nxt_w = S_CMD; end
      S_CMD:  begin byte_ok = 1'b1; nxt_w = S_CNT; end
      S_CNT:  begin byte_ok = (sr != 8'd0) && (sr <= MAXC); nxt_w = S_DATA; end
      S_DATA: begin byte_ok = (dcnt_q < cnt_q) && (dcnt_q < NR8); nxt_w = S_DATA; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      nxt_q    <= S_IDLE;
      bit_q    <= '0;
      in_ack   <= 1'b0;
      sr       <= '0;
      cnt_q    <= '0;
      dcnt_q   <= '0;
      sda_pd_o <= 1'b0;
      regs_q   <= '1;
    end else if (start_w) begin
      st       <= S_ADDR;
      bit_q    <= '0;
      in_ack   <= 1'b0;
      dcnt_q   <= '0;
      sda_pd_o <= 1'b0;
    end else if (stop_w) begin
      st       <= S_IDLE;
      in_ack   <= 1'b0;
      sda_pd_o <= 1'b0;
    end else if (active) begin
      if (rise_w && !in_ack && bit_q != 4'd8) begin
        sr    <= {sr[6:0], sda_s};
        bit_q <= bit_q + 4'd1;
      end else if (fall_w && !in_ack && bit_q == 4'd8) begin
        in_ack   <= 1'b1;
        sda_pd_o <= byte_ok;
        nxt_q    <= byte_ok ? nxt_w : S_SKIP;
        if (st == S_CNT) cnt_q <= sr;
        if (st == S_DATA && byte_ok) begin
          for (int i = 0; i < NREGS; i++)
            if (dcnt_q == 8'(i)) regs_q[i*8 +: 8] <= sr;
          dcnt_q <= dcnt_q + 8'd1;
        end
      end else if (fall_w && in_ack) begin
        in_ack   <= 1'b0;
        sda_pd_o <= 1'b0;
        bit_q    <= '0;
        st       <= nxt_q;
      end
    end
  end
endmodule

module smb_cfg_slave_chk #(
  parameter int NREGS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               sda_pd,
  input logic [NREGS*8-1:0] regs,
  input logic [2:0]         st,
  input logic [3:0]         bitc,
  input logic [7:0]         dcnt
);
  p_write_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> $rose(sda_pd));

  p_pd_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pd) |-> !scl_s);

  p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 || st == 3'd5) |-> !sda_pd);

  p_index_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= 8'(NREGS));

  p_bit_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bitc <= 4'd8);
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_p[1]), .sda_pd(sda_pd_o),
  .regs(regs_o), .st(st), .bitc(bit_q), .dcnt(dcnt_q)
);

// File: tb/smb_cfg_slave_tb.sv
module smb_cfg_slave_tb;
  localparam int NREGS = 4;
  localparam int Q     = 6;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_pd_o;
  logic [NREGS*8-1:0] regs_o;
  wire  sda_line = sda_m & ~sda_pd_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] tx [0:39];
  logic [NREGS*8-1:0] exp_regs;
  bit done = 0;

  always #2 clk = ~clk;

  smb_cfg_slave #(.NREGS(NREGS)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pd_o(sda_pd_o), .regs_o(regs_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack = sda_pd_o; tick(Q); scl_m = 0; tick(Q);
  endtask

  function automatic bit byte_ok(input int k);
    if (k == 0) return tx[0] == 8'hD2;
    if (k == 1) return 1'b1;
    if (k == 2) return tx[2] >= 8'd1 && tx[2] <= 8'd32;
    return (k - 3) < int'(tx[2]) && (k - 3) < NREGS;
  endfunction

  function automatic string tag(input int k);
    if (k == 0) return "R2";
    if (k == 1) return "R3";
    if (k == 2) return "R4";
    if ((k - 3) < int'(tx[2]) && (k - 3) < NREGS) return "R5";
    return "R6";
  endfunction

  // sends tx[0..nb-1] after a start; models acks and register updates
  task automatic xfer(input int nb, input bit do_stop);
    bit alive = 1;
    logic ack;
    bus_start();
    for (int k = 0; k < nb; k++) begin
      bit e = alive && byte_ok(k);
      send_byte(tx[k], ack);
      check(tag(k), 64'(ack), 64'(e));
      if (e && k >= 3) exp_regs[(k-3)*8 +: 8] = tx[k];
      alive = e;
    end
    if (do_stop) begin
      bus_stop();
      check("R5/R7 regs", 64'(regs_o), 64'(exp_regs));
    end
  endtask

  task automatic setup(input logic [7:0] a, input logic [7:0] c, input logic [7:0] n);
    tx[0] = a; tx[1] = c; tx[2] = n;
    for (int i = 3; i < 40; i++) tx[i] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'd7));
    exp_regs = '1;
    tick(5); rst_n = 1; tick(3);
    check("R1 regs", 64'(regs_o), 64'(exp_regs));
    check("R1 pd", 64'(sda_pd_o), 64'd0);

    setup(8'hD2, 8'h00, 8'd4); xfer(7, 1);          // R5 full bank
    setup(8'hD4, 8'h00, 8'd2); xfer(5, 1);          // R2 wrong address
    setup(8'hD3, 8'h00, 8'd2); xfer(5, 1);          // R2 read direction
    setup(8'hD2, 8'h5A, 8'd0); xfer(5, 1);          // R4 zero count, R3 any command
    setup(8'hD2, 8'h00, 8'd33); xfer(5, 1);         // R4 count too large
    setup(8'hD2, 8'h00, 8'd32); xfer(8, 1);         // R4 max count, R6 bank limit
    setup(8'hD2, 8'h00, 8'd2); xfer(6, 1);          // R6 beyond count
    setup(8'hD2, 8'h00, 8'd1); xfer(4, 1);          // R4 min count

    // R7: stop mid byte after one complete data byte
    setup(8'hD2, 8'h00, 8'd3); xfer(4, 0);
    send_bits(tx[4], 4); bus_stop();
    check("R7 partial", 64'(regs_o), 64'(exp_regs));

    // R8: repeated start mid byte, then a new full transfer
    setup(8'hD2, 8'h00, 8'd2); xfer(3, 0);
    send_bits(8'h00, 5);
    setup(8'hD2, 8'h11, 8'd2); xfer(5, 1);
    check("R8 restart", 64'(regs_o), 64'(exp_regs));

    // R8: repeated start after a rejected address
    setup(8'hA0, 8'h00, 8'd1); xfer(2, 0);
    setup(8'hD2, 8'h00, 8'd3); xfer(6, 1);

    for (int t = 0; t < 30; t++) begin
      logic [7:0] a, n;
      int nd;
      a = ($urandom % 5 == 0) ? 8'($urandom) : 8'hD2;
      case ($urandom % 6)
        0: n = 8'd0;
        1: n = 8'd33 + 8'($urandom % 4);
        default: n = 8'd1 + 8'($urandom % 6);
      endcase
      nd = $urandom % 7;
      setup(a, 8'($urandom), n);
      xfer(3 + nd, 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule